// File: doc/BRIEF.md
# Indirect Interrupt Router Register Window

This block is the register front end of a programmable interrupt router. A bus master sees only two locations. One is an 8-bit select register. The other is a 32-bit data window. The select value chooses what the window reaches: a read-only version word, a 4-bit router ID, an arbitration word that mirrors the ID, or one half of a 64-bit per-pin redirection entry. Each entry is split over two consecutive select values. The even value reaches bits 31:0 and the odd value reaches bits 63:32.

The whole redirection table is driven out in parallel for the delivery logic. The block also emits two kinds of one-cycle notification after window writes. The first reports that an entry's mask bit changed, with the pin and the new mask. The second asks for service when the written entry is level-triggered and that pin's pending-request input is high. Delivery, pin sampling and address decoding outside the two locations belong to neighbouring blocks.

Entry layout: vector in bits 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote-IRR in 14, trigger mode in 15 (1 = level), mask in 16, destination in 63:56.

Top module: `irq_regwin`

## Requirements
- R1: A bus write to address 0 stores bus_wdata[7:0] in the select register and discards the upper bits. A read of address 0 returns the select value zero-extended to 32 bits.
- R2: When the select value is 0x01, a window read returns NUM_PINS-1 in bits 23:16, VERSION in bits 7:0 and zeros elsewhere (0x00170011 with the defaults). A window write at this select changes neither the ID nor any entry.
- R3: A window write at select 0x00 loads the ID from bus_wdata[27:24]. Window reads at select 0x00 and 0x02 both return the ID in bits 27:24 and zeros elsewhere. A window write at select 0x02 is ignored.
- R4: For select values of 0x10 and above, the entry number is (select-0x10)>>1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. Entry i appears on table_out[64*i+63 : 64*i].
- R5: For an entry number of NUM_PINS or more, a window read returns 0xFFFFFFFF. A window write to such an entry leaves table_out unchanged and raises no notification.
- R6: A write to the low half replaces entry bits 31:0 and forces bit 14 (remote-IRR) to 0. A write to the high half replaces bits 63:32 only.
- R7: When a window write changes bit 16 of an entry, mask_evt_valid is high for exactly the one cycle after the write strobe. During that cycle mask_evt_pin holds the entry number and mask_evt_value holds the new bit 16. A write that leaves bit 16 unchanged raises no pulse.
- R8: When a window write hits an in-range entry whose resulting bit 15 is 1 while pin_irr for that pin is 1, svc_req_valid is high for the one cycle after the strobe, with svc_req_pin holding the entry number. An edge-triggered result, or a low pin_irr, raises no request. Writes to either half count.
- R9: After reset, every entry reads 0x0000_0000_0001_0000 (only the mask set), the select register is 0, the ID is 0, and bus_rdata is 0.
- R10: Read data appears on bus_rdata on the cycle after the read strobe and holds until the next read. Window reads at select values 0x03 to 0x0F return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = select register, 1 = data window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| pin_irr | input | NUM_PINS | Pending request level per pin |
| table_out | output | 64*NUM_PINS | Flattened redirection table |
| mask_evt_valid | output | 1 | Mask-change pulse |
| mask_evt_pin | output | clog2(NUM_PINS) | Entry whose mask changed |
| mask_evt_value | output | 1 | New mask value |
| svc_req_valid | output | 1 | Service request pulse |
| svc_req_pin | output | clog2(NUM_PINS) | Pin to be serviced |

## Verification
The hardest situation to reach from the ports is a service request raised by a write to the high half of an entry. The trigger bit lives in the low half, so it must already be level. The pin's pending input must also be held high while the write occurs. The stimulus first programs the low half as level-triggered while pin_irr is low, which must give no request. It then raises pin_irr and writes only the odd select. The same sequence also covers the mask-change pulse and a remote-IRR bit that was written as 1 and must read back as 0.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int SEL_W  = 8;
  localparam int WORD_W = 32;
  localparam int ENT_W  = 64;

  localparam logic [SEL_W-1:0] SEL_IDW  = 8'h00;
  localparam logic [SEL_W-1:0] SEL_VERW = 8'h01;
  localparam logic [SEL_W-1:0] SEL_ARBW = 8'h02;
  localparam logic [SEL_W-1:0] SEL_TBL0 = 8'h10;

  // Window target selected by the current select value
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_IDW,
    TGT_VERW,
    TGT_ARBW,
    TGT_ENT,
    TGT_ENT_OOR
  } win_tgt_e;

  typedef struct packed {
    win_tgt_e    tgt;
    logic [6:0]  ent;   // entry number derived from select
    logic        hi;    // odd select reaches bits 63:32
  } win_dec_t;

  // Redirection entry layout
  typedef struct packed {
    logic [7:0]  dest;
    logic [38:0] rsvd;
    logic        mask;
    logic        level;
    logic        rirr;
    logic        pol;
    logic        dstat;
    logic        dmode;
    logic [2:0]  dlv;
    logic [7:0]  vec;
  } redir_ent_t;

  localparam redir_ent_t ENT_RESET = '{mask: 1'b1, default: '0};

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic [SEL_W-1:0] sel,
  output win_dec_t         dec
);

  localparam logic [6:0] ENT_LIMIT = 7'(NUM_PINS);

  logic [SEL_W-1:0] ofs;

  always_comb begin
    ofs     = sel - SEL_TBL0;
    dec.ent = '0;
    dec.hi  = sel[0];
    dec.tgt = TGT_NONE;
    if (sel >= SEL_TBL0) begin
      dec.ent = ofs[7:1];
      dec.tgt = (ofs[7:1] < ENT_LIMIT) ? TGT_ENT : TGT_ENT_OOR;
    end else begin
      unique case (sel)
        SEL_IDW:  dec.tgt = TGT_IDW;
        SEL_VERW: dec.tgt = TGT_VERW;
        SEL_ARBW: dec.tgt = TGT_ARBW;
        default:  dec.tgt = TGT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/regwin_table.sv
module regwin_table
  import regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PIN_W-1:0]          wr_ent,
  input  logic                      wr_hi,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [NUM_PINS*ENT_W-1:0] tbl_flat,
  output redir_ent_t                old_ent,
  output redir_ent_t                new_ent
);

  redir_ent_t ent_arr [NUM_PINS];

  // Pick the addressed entry without indexing past the table
  always_comb begin
    old_ent = ENT_RESET;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (wr_ent == PIN_W'(i)) old_ent = ent_arr[i];
    end
  end

  // Merge one written half into the addressed entry
  always_comb begin
    new_ent = old_ent;
    if (wr_hi) begin
      new_ent[ENT_W-1:WORD_W] = wr_data;
    end else begin
      new_ent[WORD_W-1:0] = wr_data;
      new_ent.rirr        = 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    redir_ent_t q;
    logic       hit;

    assign hit = wr_en && (wr_ent == PIN_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= ENT_RESET;
      end else if (hit) begin
        q <= new_ent;
      end
    end

    assign ent_arr[i] = q;
    assign tbl_flat[i*ENT_W +: ENT_W] = q;

    // R6: a low-half write leaves remote-IRR clear
    p_low_clears_rirr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !wr_hi |=> !q.rirr);

    // R6: a high-half write keeps bits 31:0
    p_hi_keeps_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit && wr_hi |=> q[WORD_W-1:0] == $past(q[WORD_W-1:0]));
  end

endmodule

// File: rtl/regwin_notify.sv
module regwin_notify
  import regwin_pkg::*;
#(
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PIN_W-1:0] wr_ent,
  input  redir_ent_t       old_ent,
  input  redir_ent_t       new_ent,
  input  logic             irr_bit,
  output logic             mask_evt_valid,
  output logic [PIN_W-1:0] mask_evt_pin,
  output logic             mask_evt_value,
  output logic             svc_req_valid,
  output logic [PIN_W-1:0] svc_req_pin
);

  logic mask_fire_d;
  logic svc_fire_d;

  always_comb begin
    mask_fire_d = wr_en && (old_ent.mask != new_ent.mask);
    svc_fire_d  = wr_en && new_ent.level && irr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_evt_valid <= 1'b0;
      svc_req_valid  <= 1'b0;
    end else begin
      mask_evt_valid <= mask_fire_d;
      svc_req_valid  <= svc_fire_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_evt_pin   <= '0;
      mask_evt_value <= 1'b0;
    end else if (mask_fire_d) begin
      mask_evt_pin   <= wr_ent;
      mask_evt_value <= new_ent.mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_req_pin <= '0;
    end else if (svc_fire_d) begin
      svc_req_pin <= wr_ent;
    end
  end

  // R7: a mask pulse only follows an accepted entry write
  p_mask_evt_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt_valid |-> $past(wr_en));

  // R8: a service pulse only follows an accepted entry write
  p_svc_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req_valid |-> $past(wr_en));

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import regwin_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_valid,
  input  logic                          bus_write,
  input  logic                          bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_PINS-1:0]           pin_irr,
  output logic [NUM_PINS*64-1:0]        table_out,
  output logic                          mask_evt_valid,
  output logic [$clog2(NUM_PINS)-1:0]   mask_evt_pin,
  output logic                          mask_evt_value,
  output logic                          svc_req_valid,
  output logic [$clog2(NUM_PINS)-1:0]   svc_req_pin
);

  localparam int         PIN_W   = $clog2(NUM_PINS);
  localparam logic [7:0] MAX_PIN = 8'(NUM_PINS - 1);
  localparam logic [31:0] VER_WORD = {8'h00, MAX_PIN, 8'h00, VERSION};

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  // Access qualifiers
  logic sel_wr, win_wr, rd_en;
  assign sel_wr = bus_valid && bus_write && !bus_addr;
  assign win_wr = bus_valid && bus_write &&  bus_addr;
  assign rd_en  = bus_valid && !bus_write;

  // Select register
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb sel_d = bus_wdata[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     sel_q <= '0;
    else if (sel_wr) sel_q <= sel_d;
  end

  win_dec_t dec;

  regwin_decode #(.NUM_PINS(NUM_PINS)) u_decode (
    .sel (sel_q),
    .dec (dec)
  );

  // ID register; the arbitration word only mirrors it
  logic [3:0] id_q, id_d;
  logic       id_we;

  always_comb begin
    id_we = win_wr && (dec.tgt == TGT_IDW);
    id_d  = bus_wdata[27:24];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    id_q <= '0;
    else if (id_we) id_q <= id_d;
  end

  // Redirection table
  logic             ent_we;
  logic [PIN_W-1:0] ent_idx;
  redir_ent_t       old_ent, new_ent;

  assign ent_we  = win_wr && (dec.tgt == TGT_ENT);
  assign ent_idx = dec.ent[PIN_W-1:0];

  regwin_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (ent_we),
    .wr_ent   (ent_idx),
    .wr_hi    (dec.hi),
    .wr_data  (bus_wdata),
    .tbl_flat (table_out),
    .old_ent  (old_ent),
    .new_ent  (new_ent)
  );

  // Pending level of the addressed pin
  logic irr_sel;
  always_comb begin
    irr_sel = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (ent_idx == PIN_W'(i)) irr_sel = pin_irr[i];
    end
  end

  regwin_notify #(.PIN_W(PIN_W)) u_notify (
    .clk            (clk),
    .rst_n          (rst_sn),
    .wr_en          (ent_we),
    .wr_ent         (ent_idx),
    .old_ent        (old_ent),
    .new_ent        (new_ent),
    .irr_bit        (irr_sel),
    .mask_evt_valid (mask_evt_valid),
    .mask_evt_pin   (mask_evt_pin),
    .mask_evt_value (mask_evt_value),
    .svc_req_valid  (svc_req_valid),
    .svc_req_pin    (svc_req_pin)
  );

  // Read path
  logic [63:0] rd_ent;
  logic [31:0] win_word, rdata_d;

  always_comb begin
    rd_ent = '1;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (ent_idx == PIN_W'(i)) rd_ent = table_out[i*64 +: 64];
    end
  end

  always_comb begin
    unique case (dec.tgt)
      TGT_IDW, TGT_ARBW: win_word = {4'h0, id_q, 24'h0};
      TGT_VERW:          win_word = VER_WORD;
      TGT_ENT:           win_word = dec.hi ? rd_ent[63:32] : rd_ent[31:0];
      TGT_ENT_OOR:       win_word = '1;
      default:           win_word = '0;
    endcase
    rdata_d = bus_addr ? win_word : {24'h0, sel_q};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rdata_d;
  end

  // Entry fields named by the notification pins
  logic evt_mask_now, svc_level_now;
  always_comb begin
    evt_mask_now  = 1'b0;
    svc_level_now = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (mask_evt_pin == PIN_W'(i)) evt_mask_now  = table_out[i*64 + 16];
      if (svc_req_pin  == PIN_W'(i)) svc_level_now = table_out[i*64 + 15];
    end
  end

  p_sel_low8_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    sel_wr |=> sel_q == $past(bus_wdata[7:0]));

  p_ver_readonly_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    win_wr && dec.tgt == TGT_VERW |=> $stable(id_q) && $stable(table_out));

  p_id_load_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    id_we |=> id_q == $past(bus_wdata[27:24]));

  p_oor_discard_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    win_wr && dec.tgt == TGT_ENT_OOR |=> $stable(table_out) && !mask_evt_valid);

  p_mask_evt_value_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    mask_evt_valid |-> evt_mask_now == mask_evt_value);

  p_svc_level_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    svc_req_valid |-> svc_level_now);

  p_sel_read_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    rd_en && !bus_addr |=> bus_rdata == {24'h0, $past(sel_q)});

endmodule

// File: tb/tb_irq_regwin.sv
`timescale 1ns/1ps
module tb_irq_regwin;

  localparam int NP = 24;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_valid, bus_write, bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NP-1:0]   pin_irr;
  logic [NP*64-1:0] table_out;
  logic            mask_evt_valid, mask_evt_value, svc_req_valid;
  logic [4:0]      mask_evt_pin, svc_req_pin;

  always #4 clk = ~clk;

  irq_regwin #(.NUM_PINS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_irr(pin_irr), .table_out(table_out),
    .mask_evt_valid(mask_evt_valid), .mask_evt_pin(mask_evt_pin),
    .mask_evt_value(mask_evt_value), .svc_req_valid(svc_req_valid),
    .svc_req_pin(svc_req_pin)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic       ev_m, ev_mv, ev_s;
  logic [4:0] ev_mp, ev_sp;

  // Vector: we, addr, wdata, check, expected rdata, requirement number
  localparam int NV = 34;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0,1'b0,32'h0,        1'b1,32'h0000_0000,4'd9},  // R9 select after reset
    {1'b1,1'b0,32'h0000_0A01,1'b0,32'h0,        4'd1},
    {1'b0,1'b0,32'h0,        1'b1,32'h0000_0001,4'd1},  // R1 low 8 bits kept
    {1'b0,1'b1,32'h0,        1'b1,32'h0017_0011,4'd2},  // R2 version word
    {1'b1,1'b1,32'hFFFF_FFFF,1'b0,32'h0,        4'd2},
    {1'b0,1'b1,32'h0,        1'b1,32'h0017_0011,4'd2},  // R2 write ignored
    {1'b1,1'b0,32'h0000_0000,1'b0,32'h0,        4'd3},
    {1'b1,1'b1,32'hA5F0_1234,1'b0,32'h0,        4'd3},
    {1'b0,1'b1,32'h0,        1'b1,32'h0500_0000,4'd3},  // R3 ID from 27:24
    {1'b1,1'b0,32'h0000_0002,1'b0,32'h0,        4'd3},
    {1'b0,1'b1,32'h0,        1'b1,32'h0500_0000,4'd3},  // R3 arbitration mirrors ID
    {1'b1,1'b1,32'h0F00_0000,1'b0,32'h0,        4'd3},
    {1'b0,1'b1,32'h0,        1'b1,32'h0500_0000,4'd3},  // R3 arbitration write ignored
    {1'b1,1'b0,32'h0000_0016,1'b0,32'h0,        4'd4},
    {1'b0,1'b1,32'h0,        1'b1,32'h0001_0000,4'd9},  // R9 entry 3 low after reset
    {1'b1,1'b1,32'h0000_C0AB,1'b0,32'h0,        4'd6},
    {1'b0,1'b1,32'h0,        1'b1,32'h0000_80AB,4'd6},  // R6 remote-IRR forced 0
    {1'b1,1'b0,32'h0000_0017,1'b0,32'h0,        4'd4},
    {1'b0,1'b1,32'h0,        1'b1,32'h0000_0000,4'd9},  // R9 high half zero
    {1'b1,1'b1,32'hDE00_0000,1'b0,32'h0,        4'd4},
    {1'b0,1'b1,32'h0,        1'b1,32'hDE00_0000,4'd4},  // R4 odd select
    {1'b1,1'b0,32'h0000_0016,1'b0,32'h0,        4'd4},
    {1'b0,1'b1,32'h0,        1'b1,32'h0000_80AB,4'd6},  // R6 high write kept low
    {1'b1,1'b0,32'h0000_0040,1'b0,32'h0,        4'd5},
    {1'b0,1'b1,32'h0,        1'b1,32'hFFFF_FFFF,4'd5},  // R5 entry 24 low
    {1'b1,1'b0,32'h0000_0041,1'b0,32'h0,        4'd5},
    {1'b0,1'b1,32'h0,        1'b1,32'hFFFF_FFFF,4'd5},  // R5 entry 24 high
    {1'b1,1'b0,32'h0000_002F,1'b0,32'h0,        4'd4},
    {1'b0,1'b1,32'h0,        1'b1,32'h0000_0000,4'd4},  // R4 entry 15 high
    {1'b1,1'b0,32'h0000_0005,1'b0,32'h0,        4'd10},
    {1'b0,1'b1,32'h0,        1'b1,32'h0000_0000,4'd10}, // R10 gap select reads 0
    {1'b1,1'b0,32'h0000_003F,1'b0,32'h0,        4'd4},
    {1'b1,1'b1,32'h1234_5678,1'b0,32'h0,        4'd4},
    {1'b0,1'b1,32'h0,        1'b1,32'h1234_5678,4'd4}   // R4 last entry high
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    ev_m = mask_evt_valid; ev_mp = mask_evt_pin; ev_mv = mask_evt_value;
    ev_s = svc_req_valid;  ev_sp = svc_req_pin;
  endtask

  function automatic logic [63:0] ent(input int i);
    return table_out[i*64 +: 64];
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic ok;
    logic [NP*64-1:0] snap;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 1'b0;
    bus_wdata = '0; pin_irr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state of the table and read data
    ok = 1'b1;
    for (int i = 0; i < NP; i++) if (ent(i) !== 64'h0000_0000_0001_0000) ok = 1'b0;
    check("R9 all entries masked", {63'h0, ok}, 64'h1);
    check("R9 rdata", {32'h0, bus_rdata}, 64'h0);
    check("R9 no events", {62'h0, mask_evt_valid, svc_req_valid}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      access(VEC[v][70], VEC[v][69], VEC[v][68:37]);
      if (VEC[v][36]) begin
        n_checks++;
        if (bus_rdata !== VEC[v][35:4]) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h",
                   VEC[v][3:0], v, bus_rdata, VEC[v][35:4]);
        end
      end
    end

    // R4: table_out placement
    check("R4 entry3 on table_out", ent(3), 64'hDE00_0000_0000_80AB);
    check("R4 entry23 high", {32'h0, ent(23)[63:32]}, 64'h1234_5678);
    // R10: read data holds without a new read
    @(negedge clk);
    check("R10 rdata holds", {32'h0, bus_rdata}, 64'h1234_5678);

    // R7: mask change pulse on entry 5
    access(1'b1, 1'b0, 32'h1A);
    access(1'b1, 1'b1, 32'h0000_0030);
    check("R7 unmask pulse", {57'h0, ev_m, ev_mp, ev_mv}, {57'h0, 1'b1, 5'd5, 1'b0});
    check("R8 edge no svc", {63'h0, ev_s}, 64'h0);
    @(negedge clk);
    check("R7 pulse one cycle", {63'h0, mask_evt_valid}, 64'h0);
    access(1'b1, 1'b1, 32'h0000_0030);
    check("R7 unchanged mask no pulse", {63'h0, ev_m}, 64'h0);
    access(1'b1, 1'b1, 32'h0001_0030);
    check("R7 mask pulse", {57'h0, ev_m, ev_mp, ev_mv}, {57'h0, 1'b1, 5'd5, 1'b1});
    access(1'b1, 1'b0, 32'h1B);
    access(1'b1, 1'b1, 32'hFF00_0000);
    check("R7 high write no pulse", {63'h0, ev_m}, 64'h0);

    // R8: service requests on entry 7
    pin_irr = 24'h00_0080;
    access(1'b1, 1'b0, 32'h1E);
    access(1'b1, 1'b1, 32'h0000_8040);
    check("R8 level svc", {58'h0, ev_s, ev_sp}, {58'h0, 1'b1, 5'd7});
    check("R7 pin7 unmask", {57'h0, ev_m, ev_mp, ev_mv}, {57'h0, 1'b1, 5'd7, 1'b0});
    @(negedge clk);
    check("R8 svc one cycle", {63'h0, svc_req_valid}, 64'h0);
    access(1'b1, 1'b1, 32'h0000_0040);
    check("R8 edge result no svc", {63'h0, ev_s}, 64'h0);
    pin_irr = '0;
    access(1'b1, 1'b1, 32'h0000_8040);
    check("R8 irr low no svc", {63'h0, ev_s}, 64'h0);
    pin_irr = 24'h00_0080;
    access(1'b1, 1'b0, 32'h1F);
    access(1'b1, 1'b1, 32'h0000_0000);
    check("R8 high-half write svc", {58'h0, ev_s, ev_sp}, {58'h0, 1'b1, 5'd7});
    pin_irr = '0;

    // R5: write beyond the table is discarded
    access(1'b1, 1'b0, 32'h40);
    snap = table_out;
    access(1'b1, 1'b1, 32'hFFFF_FFFF);
    check("R5 oor write table", {63'h0, table_out === snap}, 64'h1);
    check("R5 oor write no event", {62'h0, ev_m, ev_s}, 64'h0);

    // R2: version write leaves the table and ID alone
    access(1'b1, 1'b0, 32'h01);
    snap = table_out;
    access(1'b1, 1'b1, 32'h0000_0000);
    check("R2 version write table", {63'h0, table_out === snap}, 64'h1);
    access(1'b1, 1'b0, 32'h00);
    access(1'b0, 1'b1, 32'h0);
    check("R2 version write ID", {32'h0, bus_rdata}, 64'h0500_0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule